// File: doc/BRIEF.md
# Track-Mode Address/Data Pass-Through Port

This block lets an 8-bit side port follow a microcontroller's multiplexed address/data bus so that a shared resource, such as a mailbox RAM or a second processor, can be reached through it. Three decoded enables come in from outside. One lets the port show the low address byte while the address strobe is high. One lets the port value go back onto the bus during a read. One lets bus write data go out on the port during a write. When no phase is active, both sides are released.

The bus may use either of two strobe styles. In the first, there are separate active-low read and write strobes. In the second, there is a read/write level with an active-high data strobe. All inputs are sampled on the block clock, and every output is registered.

A small state machine tracks the phase. IDLE releases both sides. ADDR drives the address onto the port. READ drives the port value onto the bus. WRITE drives write data onto the port. WHOLD keeps the last write byte on the port for one cycle after the write strobe ends.

The transitions are evaluated every cycle, in priority order:
- go_addr: the address strobe and the address enable are both high.
- go_read: a decoded read and the data-in enable are both high.
- go_write: a decoded write and the data-out enable are both high.
- go_hold: the machine was in WRITE and none of the above applies.
- go_idle: anything else.

Top module: `track_port`

## Requirements
- R1: While reset is asserted, port_oe and bus_oe are 0, and port_out and bus_out are 0.
- R2: When addr_stb and en_addr are both 1 at a clock edge, port_oe is 1 and port_out equals the bus_in byte of that edge from the next cycle on.
- R3: Once addr_stb falls and no other phase applies, port_oe returns to 0 one cycle later.
- R4: In a read with en_din = 1, bus_oe is 1 and bus_out equals the port_in byte of the previous edge, one cycle after sampling. A read is rd_n = 0 when strobe_mode = 0, or ds_e = 1 with rw = 1 when strobe_mode = 1.
- R5: In a write with en_dout = 1, port_oe is 1 and port_out equals the bus_in byte of the previous edge, one cycle after sampling. A write is wr_n = 0 when strobe_mode = 0, or ds_e = 1 with rw = 0 when strobe_mode = 1.
- R6: In the first cycle after a write phase ends with no other phase applying, the port stays driven with the last write byte.
- R7: A strobe whose own enable is 0 has no effect: both sides stay released.
- R8: With strobe_mode = 1, rd_n and wr_n are ignored and only ds_e and rw decode read and write.
- R9: port_oe and bus_oe are never 1 in the same cycle.
- R10: When the address phase coincides with a read or write, the address phase wins. When a read and a write coincide, the read wins.
- R11: When all three enables have been 0 for two consecutive sampled cycles, both sides are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_mode | input | 1 | 0: separate read/write strobes; 1: read/write level plus data strobe |
| addr_stb | input | 1 | Address strobe, active high |
| rd_n | input | 1 | Read strobe, active low (mode 0) |
| wr_n | input | 1 | Write strobe, active low (mode 0) |
| rw | input | 1 | 1 read, 0 write (mode 1) |
| ds_e | input | 1 | Data strobe, active high (mode 1) |
| en_addr | input | 1 | Decoded address-out enable (from unlatched terms) |
| en_din | input | 1 | Decoded data-in enable |
| en_dout | input | 1 | Decoded data-out enable |
| bus_in | input | 8 | Byte on the microcontroller address/data bus |
| bus_out | output | 8 | Byte driven back onto the bus |
| bus_oe | output | 1 | Bus-side drive enable |
| port_in | input | 8 | Byte seen on the side port |
| port_out | output | 8 | Byte driven onto the side port |
| port_oe | output | 1 | Port-side drive enable |

## Verification
On every cycle, the assertions check the following:
- the two drive enables never overlap;
- an address sample is followed by the address byte on the port;
- an enabled read is followed by the port byte on the bus;
- the bus drive only ever follows a data-in enable;
- two cycles with every enable low always release both sides.

Some behaviours can only be shown by the bench's scenarios:
- the one-cycle write hold and its value;
- the priority between coincident phases;
- strobes being ignored when their enable is low;
- the strobe-style selection, including rd_n and wr_n being ignored in the second style.

// File: rtl/track_pkg.sv
package track_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_READ  = 3'd2,
        PH_WRITE = 3'd3,
        PH_WHOLD = 3'd4
    } phase_e;
endpackage

// File: rtl/track_strobe_dec.sv
module track_strobe_dec (
    input  logic strobe_mode,
    input  logic rd_n,
    input  logic wr_n,
    input  logic rw,
    input  logic ds_e,
    output logic rd_act,
    output logic wr_act
);
    always_comb begin
        if (strobe_mode) begin
            rd_act = ds_e & rw;
            wr_act = ds_e & ~rw;
        end else begin
            rd_act = ~rd_n;
            wr_act = ~wr_n;
        end
    end
endmodule

// File: rtl/track_phase_fsm.sv
module track_phase_fsm
    import track_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   addr_stb,
    input  logic   en_addr,
    input  logic   rd_act,
    input  logic   wr_act,
    input  logic   en_din,
    input  logic   en_dout,
    output phase_e nxt
);
    phase_e cur;

    always_comb begin
        if (addr_stb && en_addr)       nxt = PH_ADDR;   // go_addr
        else if (rd_act && en_din)     nxt = PH_READ;   // go_read
        else if (wr_act && en_dout)    nxt = PH_WRITE;  // go_write
        else if (cur == PH_WRITE)      nxt = PH_WHOLD;  // go_hold
        else                           nxt = PH_IDLE;   // go_idle
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= PH_IDLE;
        else        cur <= nxt;
    end
endmodule

// File: rtl/track_drive_regs.sv
module track_drive_regs
    import track_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            nxt,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out  <= '0;
            bus_oe   <= 1'b0;
            port_out <= '0;
            port_oe  <= 1'b0;
        end else begin
            unique case (nxt)
                PH_ADDR, PH_WRITE: begin
                    port_out <= bus_in;
                    port_oe  <= 1'b1;
                    bus_out  <= '0;
                    bus_oe   <= 1'b0;
                end
                PH_READ: begin
                    bus_out  <= port_in;
                    bus_oe   <= 1'b1;
                    port_out <= '0;
                    port_oe  <= 1'b0;
                end
                PH_WHOLD: begin
                    port_oe  <= 1'b1;
                    bus_out  <= '0;
                    bus_oe   <= 1'b0;
                end
                default: begin
                    bus_out  <= '0;
                    bus_oe   <= 1'b0;
                    port_out <= '0;
                    port_oe  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/track_port.sv
module track_port
    import track_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_mode,
    input  logic              addr_stb,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rw,
    input  logic              ds_e,
    input  logic              en_addr,
    input  logic              en_din,
    input  logic              en_dout,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe
);
    logic   rd_act;
    logic   wr_act;
    phase_e nxt;

    track_strobe_dec u_dec (
        .strobe_mode (strobe_mode),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .rw          (rw),
        .ds_e        (ds_e),
        .rd_act      (rd_act),
        .wr_act      (wr_act)
    );

    track_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_stb (addr_stb),
        .en_addr  (en_addr),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .en_din   (en_din),
        .en_dout  (en_dout),
        .nxt      (nxt)
    );

    track_drive_regs #(.DATA_W(DATA_W)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt      (nxt),
        .bus_in   (bus_in),
        .port_in  (port_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .port_out (port_out),
        .port_oe  (port_oe)
    );
endmodule

// File: rtl/track_port_chk.sv
module track_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_mode,
    input logic              addr_stb,
    input logic              rd_n,
    input logic              rw,
    input logic              ds_e,
    input logic              en_addr,
    input logic              en_din,
    input logic              en_dout,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic [DATA_W-1:0] port_in,
    input logic [DATA_W-1:0] port_out,
    input logic              port_oe
);
    logic read_seen;
    logic no_en;
    assign read_seen = strobe_mode ? (ds_e && rw) : !rd_n;
    assign no_en     = !en_addr && !en_din && !en_dout;

    // R9
    no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_oe && bus_oe));

    // R2
    addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && en_addr) |=> (port_oe && port_out == $past(bus_in)));

    // R4
    read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_seen && en_din && !(addr_stb && en_addr))
        |=> (bus_oe && bus_out == $past(port_in)));

    // R7
    bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(en_din));

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_en && $past(no_en)) |=> (!port_oe && !bus_oe));
endmodule

bind track_port track_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_mode (strobe_mode),
    .addr_stb    (addr_stb),
    .rd_n        (rd_n),
    .rw          (rw),
    .ds_e        (ds_e),
    .en_addr     (en_addr),
    .en_din      (en_din),
    .en_dout     (en_dout),
    .bus_in      (bus_in),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .port_in     (port_in),
    .port_out    (port_out),
    .port_oe     (port_oe)
);

// File: tb/tb_track_port.sv
`timescale 1ns/100ps
module tb_track_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_mode = 1'b0;
    logic       addr_stb = 1'b0, rd_n = 1'b1, wr_n = 1'b1, rw = 1'b1, ds_e = 1'b0;
    logic       en_addr = 1'b0, en_din = 1'b0, en_dout = 1'b0;
    logic [7:0] bus_in = '0, port_in = '0;
    logic [7:0] bus_out, port_out;
    logic       bus_oe, port_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic       p_oe;
        logic [7:0] p_val;
        logic       b_oe;
        logic [7:0] b_val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    bit         m_was_wr = 0;
    logic [7:0] m_last   = '0;

    always #2.5 clk = ~clk;

    track_port dut (
        .clk(clk), .rst_n(rst_n), .strobe_mode(strobe_mode),
        .addr_stb(addr_stb), .rd_n(rd_n), .wr_n(wr_n), .rw(rw), .ds_e(ds_e),
        .en_addr(en_addr), .en_din(en_din), .en_dout(en_dout),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .port_in(port_in), .port_out(port_out), .port_oe(port_oe)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic as_i, input logic ea, input logic rdn, input logic wrn,
                        input logic rw_i, input logic e_i, input logic edi, input logic edo,
                        input logic [7:0] b, input logic [7:0] p, input string tag);
        exp_t x;
        logic rda, wra;
        @(negedge clk);
        addr_stb = as_i; en_addr = ea; rd_n = rdn; wr_n = wrn; rw = rw_i; ds_e = e_i;
        en_din = edi; en_dout = edo; bus_in = b; port_in = p;
        rda = strobe_mode ? (e_i && rw_i) : !rdn;
        wra = strobe_mode ? (e_i && !rw_i) : !wrn;
        x.tag = tag;
        x.p_oe = 0; x.p_val = '0; x.b_oe = 0; x.b_val = '0;
        if (as_i && ea) begin
            x.p_oe = 1; x.p_val = b; m_was_wr = 0;
        end else if (rda && edi) begin
            x.b_oe = 1; x.b_val = p; m_was_wr = 0;
        end else if (wra && edo) begin
            x.p_oe = 1; x.p_val = b; m_was_wr = 1; m_last = b;
        end else if (m_was_wr) begin
            x.p_oe = 1; x.p_val = m_last; m_was_wr = 0;
        end else begin
            m_was_wr = 0;
        end
        sb.push_back(x);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 1, 1, 1, 0, 0, 0, 8'h00, 8'h00, tag);
    endtask

    // monitor: compare one cycle after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check(port_oe == x.p_oe && bus_oe == x.b_oe, x.tag,
                      $sformatf("oe port/bus act=%0b/%0b exp=%0b/%0b", port_oe, bus_oe, x.p_oe, x.b_oe));
                if (x.p_oe)
                    check(port_out == x.p_val, x.tag,
                          $sformatf("port_out act=%h exp=%h", port_out, x.p_val));
                if (x.b_oe)
                    check(bus_out == x.b_val, x.tag,
                          $sformatf("bus_out act=%h exp=%h", bus_out, x.b_val));
                // R9
                check(!(port_oe && bus_oe), "R9",
                      $sformatf("both enables act=%0b%0b exp=not both", port_oe, bus_oe));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(!port_oe && !bus_oe && port_out == 0 && bus_out == 0, "R1",
              $sformatf("reset act=%0b%0b %h %h exp=00 00 00", port_oe, bus_oe, port_out, bus_out));
        @(negedge clk);
        rst_n = 1'b1;

        strobe_mode = 1'b0;
        // R2 address then R4 read
        step(1, 1, 1, 1, 1, 0, 0, 0, 8'h5A, 8'h00, "R2");
        step(0, 0, 0, 1, 1, 0, 1, 0, 8'h00, 8'h3C, "R4");
        idle("R3");
        idle("R11");
        // R2 then R3 release
        step(1, 1, 1, 1, 1, 0, 0, 0, 8'hC3, 8'h00, "R2");
        idle("R3");
        // R7 strobes without enables
        step(1, 0, 1, 1, 1, 0, 0, 0, 8'hFF, 8'h00, "R7");
        step(0, 0, 0, 1, 1, 0, 0, 0, 8'h00, 8'h77, "R7");
        step(0, 0, 1, 0, 1, 0, 0, 0, 8'h99, 8'h00, "R7");
        // address, write, hold, release
        step(1, 1, 1, 1, 1, 0, 0, 0, 8'h12, 8'h00, "R2");
        step(0, 0, 1, 0, 1, 0, 0, 1, 8'hA7, 8'h00, "R5");
        step(0, 0, 1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R6");
        idle("R11");
        // several write patterns
        for (int i = 0; i < 4; i++)
            step(0, 0, 1, 0, 1, 0, 0, 1, 8'(8'h11 * (i + 1)), 8'h00, "R5");
        step(0, 0, 1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R6");
        idle("R11");
        // R10 priority
        step(1, 1, 0, 1, 1, 0, 1, 0, 8'h4E, 8'hE4, "R10");
        step(0, 0, 0, 0, 1, 0, 1, 1, 8'h66, 8'h5D, "R10");
        idle("R10");
        // R8 second strobe style
        strobe_mode = 1'b1;
        step(1, 1, 1, 1, 1, 0, 0, 0, 8'h80, 8'h00, "R8");
        step(0, 0, 1, 1, 1, 1, 1, 0, 8'h00, 8'h2B, "R8");
        step(0, 0, 1, 1, 0, 1, 0, 1, 8'hB2, 8'h00, "R8");
        step(0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R6");
        step(0, 0, 0, 1, 1, 0, 1, 0, 8'h00, 8'h44, "R8");
        step(0, 0, 1, 0, 1, 0, 0, 1, 8'h55, 8'h00, "R8");
        idle("R11");
        idle("R11");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule